// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block holds the software-visible state of a multi-bank GPIO controller. Pins are grouped eight to a port and four ports to a bank. Every port has its own configuration, output-enable, output-data, input-sample, interrupt-status, interrupt-enable and interrupt-type byte. Software reaches these bytes through a plain 32-bit register bus with an address, a write strobe, write data and registered read data.

Besides the direct view, each writable register group has a masked alias. A write to an alias carries a per-pin select byte in bits 15:8 and the new pin values in bits 7:0. Only the selected pins change. This lets several agents own different pins of one port without a read-modify-write sequence. Interrupt status is a plain register in this block: it can be set by writes and is cleared per pin through a write-one-to-clear group. Detecting pin events is left to logic outside this block.

The block drives a per-pin output-enable vector and a per-pin output vector. It samples a per-pin input vector through a synchronizer.

Top module: `gpio_bank_regfile`

## Requirements
- R1: A register's byte address is bank*0x100 + group*0x10 + port*4. Address bits 1:0 are ignored. The direct groups are: configuration 0, output-enable 1, output 2, input 3, status 4, interrupt-enable 5, interrupt-type 6, clear 7. A read of a direct group 0 to 6 returns that port's byte in rdata[7:0], with rdata[31:8] zero.
- R2: A write to direct group 0, 1, 2, 4, 5 or 6 replaces all eight bits of the addressed port's byte with wdata[7:0]. Bits 31:8 of the write data are ignored.
- R3: A write to the alias at group+8 (groups 8, 9, A, C, D, E) updates pin i of the addressed byte to wdata[i] only where wdata[8+i] is 1. Pins whose select bit is 0 keep their value. Bits 31:16 are ignored.
- R4: A write to group 7 clears status bit i wherever wdata[i] is 1. Every other status bit and every other register is unchanged.
- R5: The input group is read-only. Writes to group 3 and to group B change nothing. A change on pin_in reaches the input register on the third rising edge after it. A read first shows it on the fourth edge.
- R6: Reads of group 7, of any alias group 8 to F, and of any bank at or above NUM_BANKS return zero. Writes to such a bank change nothing.
- R7: pin_oe[k] is 1 exactly when pin k's configuration bit and output-enable bit are both 1. pin_out[k] is pin k's output bit while pin_oe[k] is 1, and 0 otherwise. Both follow a register write by one clock cycle and do not change while no write occurs.
- R8: On synchronous active-high reset, every register except the input register becomes zero, and rdata, pin_oe and pin_out become zero.
- R9: rdata is registered. It shows the byte addressed in the previous cycle, and that byte includes any write completed at an earlier edge.
- R10: Pin k maps to port k/8 and bit k%8. Global port index = bank*4 + port within the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wen | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin drive enables |

## Verification
The bound checker watches four properties on every cycle:
- rdata, pin_oe and pin_out are zero after reset;
- no pin shows an output value without its drive enable;
- reads of void addresses return zero;
- the pin vectors hold still in the absence of writes.

Only the bench's scenarios can show that each byte lands at the right bank, port and group. They also show the masked-merge arithmetic, the per-pin clearing of status, the exact synchronizer latency on the input group, and the absence of aliasing for out-of-range banks. To do this, the bench sweeps every port and group of a two-bank configuration against a model it builds itself.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

  localparam int PINS_PER_PORT  = 8;
  localparam int PORTS_PER_BANK = 4;
  localparam int BANK_STRIDE_W  = 8;

  typedef enum logic [2:0] {
    GRP_CFG = 3'd0,
    GRP_OE  = 3'd1,
    GRP_OUT = 3'd2,
    GRP_IN  = 3'd3,
    GRP_STS = 3'd4,
    GRP_IEN = 3'd5,
    GRP_TYP = 3'd6,
    GRP_CLR = 3'd7
  } grp_e;

  function automatic logic [PINS_PER_PORT-1:0] merge_byte(
    input logic [PINS_PER_PORT-1:0]   old_v,
    input logic [2*PINS_PER_PORT-1:0] wd,
    input logic                       masked
  );
    logic [PINS_PER_PORT-1:0] sel;
    sel = wd[2*PINS_PER_PORT-1:PINS_PER_PORT];
    if (masked) return (old_v & ~sel) | (wd[PINS_PER_PORT-1:0] & sel);
    else        return wd[PINS_PER_PORT-1:0];
  endfunction

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
  import gpio_rf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 2,
  parameter int PORT_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              masked,
  output grp_e              grp,
  output logic [PORT_W-1:0] port_idx
);

  localparam int BANK_W = ADDR_W - BANK_STRIDE_W;

  logic [BANK_W-1:0] bank;
  logic              unused_lsb;

  assign bank       = addr[ADDR_W-1:BANK_STRIDE_W];
  assign hit        = (int'(bank) < NUM_BANKS);
  assign masked     = addr[7];
  assign grp        = grp_e'(addr[6:4]);
  assign port_idx   = PORT_W'({bank, addr[3:2]});
  assign unused_lsb = ^addr[1:0];

endmodule

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= d;
    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_rf_port.sv
module gpio_rf_port
  import gpio_rf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       masked,
  input  grp_e                       grp,
  input  logic [2*PINS_PER_PORT-1:0] wd,
  input  logic [PINS_PER_PORT-1:0]   pin_sync,
  output logic [PINS_PER_PORT-1:0]   cfg_q,
  output logic [PINS_PER_PORT-1:0]   oe_q,
  output logic [PINS_PER_PORT-1:0]   out_q,
  output logic [PINS_PER_PORT-1:0]   inp_q,
  output logic [PINS_PER_PORT-1:0]   sts_q,
  output logic [PINS_PER_PORT-1:0]   ien_q,
  output logic [PINS_PER_PORT-1:0]   typ_q
);

  // input sample register is not reset: it always tracks the synchronizer
  always_ff @(posedge clk) inp_q <= pin_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      oe_q  <= '0;
      out_q <= '0;
      sts_q <= '0;
      ien_q <= '0;
      typ_q <= '0;
    end else if (wr_en) begin
      case (grp)
        GRP_CFG: cfg_q <= merge_byte(cfg_q, wd, masked);
        GRP_OE:  oe_q  <= merge_byte(oe_q,  wd, masked);
        GRP_OUT: out_q <= merge_byte(out_q, wd, masked);
        GRP_STS: sts_q <= merge_byte(sts_q, wd, masked);
        GRP_IEN: ien_q <= merge_byte(ien_q, wd, masked);
        GRP_TYP: typ_q <= merge_byte(typ_q, wd, masked);
        GRP_CLR: if (!masked) sts_q <= sts_q & ~wd[PINS_PER_PORT-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wen,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  input  logic [NUM_BANKS*32-1:0]   pin_in,
  output logic [NUM_BANKS*32-1:0]   pin_out,
  output logic [NUM_BANKS*32-1:0]   pin_oe
);

  localparam int NPORT  = NUM_BANKS * PORTS_PER_BANK;
  localparam int NPIN   = NPORT * PINS_PER_PORT;
  localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic              acc_hit;
  logic              acc_masked;
  grp_e              acc_grp;
  logic [PORT_W-1:0] acc_port;

  gpio_rf_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .PORT_W(PORT_W)
  ) u_dec (
    .addr(addr), .hit(acc_hit), .masked(acc_masked),
    .grp(acc_grp), .port_idx(acc_port)
  );

  logic [NPIN-1:0] pin_sync;

  gpio_rf_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d(pin_in), .q(pin_sync)
  );

  logic [PINS_PER_PORT-1:0] cfg_w [NPORT];
  logic [PINS_PER_PORT-1:0] oe_w  [NPORT];
  logic [PINS_PER_PORT-1:0] out_w [NPORT];
  logic [PINS_PER_PORT-1:0] inp_w [NPORT];
  logic [PINS_PER_PORT-1:0] sts_w [NPORT];
  logic [PINS_PER_PORT-1:0] ien_w [NPORT];
  logic [PINS_PER_PORT-1:0] typ_w [NPORT];

  logic unused_hi;
  assign unused_hi = ^wdata[31:16];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = wen && acc_hit && (acc_port == PORT_W'(p));

    gpio_rf_port u_port (
      .clk(clk), .rst(rst), .wr_en(sel), .masked(acc_masked), .grp(acc_grp),
      .wd(wdata[15:0]), .pin_sync(pin_sync[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .cfg_q(cfg_w[p]), .oe_q(oe_w[p]), .out_q(out_w[p]), .inp_q(inp_w[p]),
      .sts_q(sts_w[p]), .ien_q(ien_w[p]), .typ_q(typ_w[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT]  <= '0;
        pin_out[p*PINS_PER_PORT +: PINS_PER_PORT] <= '0;
      end else begin
        pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT]  <= cfg_w[p] & oe_w[p];
        pin_out[p*PINS_PER_PORT +: PINS_PER_PORT] <= out_w[p] & cfg_w[p] & oe_w[p];
      end
    end
  end

  logic [PINS_PER_PORT-1:0] rd_byte;

  always_comb begin
    rd_byte = '0;
    if (acc_hit && !acc_masked) begin
      case (acc_grp)
        GRP_CFG: rd_byte = cfg_w[acc_port];
        GRP_OE:  rd_byte = oe_w[acc_port];
        GRP_OUT: rd_byte = out_w[acc_port];
        GRP_IN:  rd_byte = inp_w[acc_port];
        GRP_STS: rd_byte = sts_w[acc_port];
        GRP_IEN: rd_byte = ien_w[acc_port];
        GRP_TYP: rd_byte = typ_w[acc_port];
        default: rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{(32-PINS_PER_PORT){1'b0}}, rd_byte};
  end

endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wen,
  input logic [31:0]             rdata,
  input logic [NUM_BANKS*32-1:0] pin_out,
  input logic [NUM_BANKS*32-1:0] pin_oe
);

  logic rd_void;
  logic unused_low;
  assign rd_void    = addr[7] || (addr[6:4] == 3'd7) ||
                      (int'(addr[ADDR_W-1:8]) >= NUM_BANKS);
  assign unused_low = ^addr[3:0];

  // R8
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (rdata == '0 && pin_oe == '0 && pin_out == '0));

  // R7
  drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  // R6
  void_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_void |=> rdata == '0);

  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !wen |=> ##1 ($stable(pin_oe) && $stable(pin_out)));

endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wen(wen), .rdata(rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_regfile_tb.sv
`timescale 1ns/1ps
module gpio_bank_regfile_tb;

  localparam int NB = 2;
  localparam int NP = NB * 4;
  localparam int NPIN = NB * 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [9:0]      addr = '0;
  logic            wen = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  logic [7:0] m [7][NP];

  always #2 clk = ~clk;

  gpio_bank_regfile #(.NUM_BANKS(NB), .ADDR_W(10), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [9:0] ad(int b, int g, int p);
    return 10'(b * 256 + g * 16 + p * 4);
  endfunction

  function automatic logic [7:0] pat(int p, int g, int s);
    return 8'(p * 37 + g * 11 + s * 71 + 90);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wen = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int g = 0; g < 7; g++)
      for (int p = 0; p < NP; p++) begin
        rd(ad(p / 4, g, p % 4), d);
        chk(req, 64'(d), 64'(m[g][p]));
      end
  endtask

  task automatic check_pins(string req);
    logic [NPIN-1:0] e_oe, e_out;
    repeat (2) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      e_oe[p*8 +: 8]  = m[0][p] & m[1][p];
      e_out[p*8 +: 8] = m[2][p] & m[0][p] & m[1][p];
    end
    chk({req, " oe"},  64'(pin_oe),  64'(e_oe));
    chk({req, " out"}, 64'(pin_out), 64'(e_out));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  msk, val, c;
    for (int g = 0; g < 7; g++) for (int p = 0; p < NP; p++) m[g][p] = '0;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    chk("R8 pin_oe", 64'(pin_oe), 64'd0);
    chk("R8 pin_out", 64'(pin_out), 64'd0);
    check_all("R8 reset read");

    // R2 direct writes with junk in upper bits; R1/R10 placement
    for (int g = 0; g < 7; g++)
      for (int p = 0; p < NP; p++)
        if (g != 3) begin
          wr(ad(p / 4, g, p % 4), {24'hC3A500, pat(p, g, 0)});
          m[g][p] = pat(p, g, 0);
        end
    check_all("R2 R1 direct readback");
    check_pins("R7 R10 after direct");

    // R9 read right after write
    wr(ad(1, 2, 3), 32'h0000_00E7);
    m[2][7] = 8'hE7;
    rd(ad(1, 2, 3), d);
    chk("R9 read after write", 64'(d), 64'hE7);

    // R3 masked aliases
    for (int g = 0; g < 7; g++)
      for (int p = 0; p < NP; p++)
        if (g != 3) begin
          msk = pat(p, g, 1);
          val = pat(p, g, 2);
          wr(ad(p / 4, g + 8, p % 4), {16'h9F3C, msk, val});
          m[g][p] = (m[g][p] & ~msk) | (val & msk);
        end
    wr(ad(0, 8, 0), 32'h0000_00FF);
    check_all("R3 masked readback");
    check_pins("R7 R10 after masked");

    // R4 clear status
    for (int p = 0; p < NP; p++) begin
      c = pat(p, 7, 3);
      wr(ad(p / 4, 7, p % 4), {24'hABCD00, c});
      m[4][p] = m[4][p] & ~c;
    end
    wr(ad(0, 15, 1), 32'h0000_FFFF);
    check_all("R4 clear status");

    // R5 input latency
    @(negedge clk);
    addr = ad(0, 3, 0);
    pin_in = {8{8'h00}} | 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    chk("R5 input not yet visible", 64'(rdata), 64'd0);
    @(negedge clk);
    chk("R5 input visible", 64'(rdata), 64'hF0);
    for (int p = 0; p < NP; p++) m[3][p] = pin_in[p*8 +: 8];
    wr(ad(0, 3, 1), 32'h0000_00FF);
    wr(ad(1, 11, 2), 32'h0000_FFFF);
    check_all("R5 input read-only");

    // R6 void reads and out-of-range banks
    for (int p = 0; p < 4; p++) begin
      for (int g = 7; g < 16; g++) begin
        rd(ad(0, g, p), d);
        chk("R6 void group read", 64'(d), 64'd0);
      end
      for (int b = 2; b < 4; b++) begin
        rd(ad(b, 0, p), d);
        chk("R6 void bank read", 64'(d), 64'd0);
      end
    end
    wr(ad(2, 0, 0), 32'h0000_005A);
    wr(ad(3, 10, 1), 32'h0000_FFFF);
    check_all("R6 void bank write");
    check_pins("R6 R7 pins after void write");

    // R8 reset again clears registers
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int g = 0; g < 7; g++) for (int p = 0; p < NP; p++) if (g != 3) m[g][p] = '0;
    check_all("R8 second reset");
    check_pins("R8 pins after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule